// File: doc/BRIEF.md
# Busy-Header Status Target on I2C

This block is an I2C target that answers status queries without ever holding the bus. A host first writes a command byte to the target's address. It then opens a read transaction. Every read begins with a one-byte header. Its low five bits are a copy of the internal status flags, and bit 0 is the busy flag. Payload bytes follow the header. The target never stretches SCL and never withholds an acknowledge, even while busy. When the header reports busy, the host discards the rest of that read and repeats the command.

The status flags are sampled once, at the moment the read address is accepted. That snapshot governs the whole read, so the header and the validity of the payload can never disagree. When the snapshot is busy, every payload bit is left released, so the payload reads as 0xFF. A read that arrives without a fresh status command returns the header followed by a fixed default byte. Both SDA and SCL pass through a two-flop synchronizer and a glitch filter before any edge is detected.

Top module: `i2c_status_target`

## Requirements
- R1: After reset, and whenever no transaction addresses the target, `sda_oe` is 0 and the target is idle.
- R2: The first byte after a START is decoded as follows. Bits 7:1 are compared with `dev_addr`, and bit 0 is the direction (1 = read). The target pulls SDA low in the acknowledge slot only on a match. On a mismatch it drives nothing for the rest of that transaction, so a read of it returns 0xFF.
- R3: In a write transaction, every data byte is acknowledged whatever its value. The byte equal to `CMD_STATUS` (default 0xC3) arms the target for the next read.
- R4: The first byte of every accepted read is the header `{3'b000, stat_in[4:0]}`, sampled when the read address is accepted. Bit 0 of `stat_in` is busy.
- R5: When the target is armed and the sampled busy bit is 0, payload byte k equals `pay_bus[8k+7:8k]` for k < `NPAY`. Bytes past `NPAY` read 0xFF.
- R6: When the sampled busy bit is 1, every payload byte reads 0xFF. The address is still acknowledged and the header is still sent.
- R7: Each accepted read consumes the arming. A read with no arming since the previous read returns payload bytes equal to `DFLT` (default 0x3C). A data byte other than `CMD_STATUS` neither arms nor disarms the target.
- R8: Changes on `stat_in` after the read address is accepted change neither the header nor the payload validity of that read.
- R9: After the host NACKs a byte, the target keeps SDA released until the next START, even if SCL keeps toggling.
- R10: `sda_oe` changes only while SCL is low. It is 0 during every host acknowledge slot of a read.
- R11: A START or repeated START at any point restarts address decoding, including in the middle of a byte. A repeated START between the command write and the read is accepted.
- R12: An SCL pulse shorter than `FLT` clock cycles is ignored and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| dev_addr | input | 7 | Target's 7-bit bus address |
| stat_in | input | 5 | Status flags: bit 0 busy, bits 4:1 other conditions |
| pay_bus | input | 8*NPAY | Parallel payload source, byte k in bits 8k+7:8k |
| sda_oe | output | 1 | SDA pull-low enable (1 = drive low) |

## Verification
The read path is exercised with random status flags and payloads. Busy and idle snapshots are mixed with armed and unarmed reads, so header bits, payload substitution and default bytes each show up in their own byte positions. Read lengths are drawn across and past `NPAY`, which separates valid payload from the 0xFF fill. Directed sequences cover the remaining cases:
- a mismatched address;
- unknown command bytes;
- a flag change in the middle of a read, which only a held snapshot survives;
- extra clocks after a NACK;
- a repeated START inside the address byte;
- sub-filter SCL pulses, which would shift the payload by a bit if they were counted.

// File: rtl/i2c_status_target.sv
module i2c_status_target #(
  parameter logic [7:0] CMD_STATUS = 8'hC3,
  parameter int NPAY = 4,
  parameter logic [7:0] DFLT = 8'h3C,
  parameter int FLT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [6:0]        dev_addr,
  input  logic [4:0]        stat_in,
  input  logic [8*NPAY-1:0] pay_bus,
  output logic              sda_oe
);
  localparam int IW = $clog2(NPAY + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2, S_WDAT = 3'd3,
    S_WACK = 3'd4, S_RDAT = 3'd5, S_RACK = 3'd6
  } st_t;

  logic [1:0]     scl_s, sda_s;
  logic [FLT-1:0] scl_h, sda_h;
  logic           scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FLT-2:0], scl_s[1]};
      sda_h <= {sda_h[FLT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  wire start_ev = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
  wire rise_ev  = scl_f & ~scl_p;
  wire fall_ev  = ~scl_f & scl_p;

  st_t          st;
  logic [3:0]   cnt;
  logic [7:0]   sh, tx;
  logic         rw, nack, armed, snap_cmd;
  logic [4:0]   snap;
  logic [IW-1:0] idx;
  logic [7:0]   pv, nxt;

  always_comb begin
    pv = 8'hFF;
    for (int i = 0; i < NPAY; i++)
      if (idx == IW'(i)) pv = pay_bus[8*i +: 8];
  end

  assign nxt = snap[0] ? 8'hFF : (!snap_cmd ? DFLT : pv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '1; rw <= 1'b0; nack <= 1'b0;
      armed <= 1'b0; snap_cmd <= 1'b0; snap <= '0; idx <= '0; sda_oe <= 1'b0;
    end else if (start_ev) begin
      st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (rise_ev) begin
      case (st)
        S_ADDR, S_WDAT: begin sh <= {sh[6:0], sda_f}; cnt <= cnt + 4'd1; end
        S_RACK:         nack <= sda_f;
        default: ;
      endcase
    end else if (fall_ev) begin
      case (st)
        S_ADDR: if (cnt == 4'd8) begin
          if (sh[7:1] == dev_addr) begin
            sda_oe <= 1'b1; st <= S_AACK; rw <= sh[0];
            if (sh[0]) begin snap <= stat_in; snap_cmd <= armed; armed <= 1'b0; end
          end else st <= S_IDLE;
        end
        S_AACK: if (rw) begin
          tx <= {3'b000, snap}; sda_oe <= 1'b1; cnt <= 4'd1; idx <= '0; st <= S_RDAT;
        end else begin
          sda_oe <= 1'b0; cnt <= '0; st <= S_WDAT;
        end
        S_WDAT: if (cnt == 4'd8) begin
          sda_oe <= 1'b1; st <= S_WACK;
          if (sh == CMD_STATUS) armed <= 1'b1;
        end
        S_WACK: begin sda_oe <= 1'b0; cnt <= '0; st <= S_WDAT; end
        S_RDAT: if (cnt == 4'd8) begin
          sda_oe <= 1'b0; st <= S_RACK;
        end else begin
          tx <= {tx[6:0], 1'b1}; sda_oe <= ~tx[6]; cnt <= cnt + 4'd1;
        end
        S_RACK: if (nack) st <= S_IDLE;
        else begin
          tx <= nxt; sda_oe <= ~nxt[7]; cnt <= 4'd1; st <= S_RDAT;
          if (idx < IW'(NPAY)) idx <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_status_target_chk.sv
module i2c_status_target_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    st,
  input logic [3:0]    cnt,
  input logic [IW-1:0] idx,
  input logic [4:0]    snap,
  input logic          sda_oe,
  input logic          scl_f,
  input logic          start_ev,
  input logic          stop_ev
);
  // state codes follow the target's enum: idle 0, addr-ack 2, read bits 5, read ack slot 6
  localparam logic [2:0] C_IDLE = 3'd0, C_AACK = 3'd2, C_RDAT = 3'd5, C_RACK = 3'd6;

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_IDLE |-> !sda_oe);

  a_r2_match_acked: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_AACK |-> sda_oe);

  a_r4_header_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RDAT && idx == '0 && cnt >= 4'd1 && cnt <= 4'd3) |-> sda_oe);

  a_r6_busy_payload_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RDAT && idx != '0 && snap[0]) |-> !sda_oe);

  a_r8_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == C_RDAT || st == C_RACK) && ($past(st) == C_RDAT || $past(st) == C_RACK))
      |-> $stable(snap));

  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> (!scl_f || $past(start_ev || stop_ev)));

  a_r10_ack_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_RACK |-> !sda_oe);
endmodule

bind i2c_status_target i2c_status_target_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .idx(idx), .snap(snap),
  .sda_oe(sda_oe), .scl_f(scl_f), .start_ev(start_ev), .stop_ev(stop_ev)
);

// File: tb/i2c_status_target_test.sv
module i2c_status_target_test;
  localparam int NPAY = 4;
  localparam logic [7:0] CMD = 8'hC3;
  localparam logic [7:0] DFLT = 8'h3C;
  localparam logic [6:0] ADDR = 7'h52;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [4:0] stat = '0;
  logic [8*NPAY-1:0] pay = '0;
  logic sda_oe;
  wire  sda_ln = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_status_target #(.CMD_STATUS(CMD), .NPAY(NPAY), .DFLT(DFLT), .FLT(3)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln), .dev_addr(ADDR),
    .stat_in(stat), .pay_bus(pay), .sda_oe(sda_oe));

  int total = 0, bad = 0, viol = 0, rel_bad = 0;
  bit mdl_arm = 0, glitch = 0, chg_en = 0;
  logic [4:0] chg_val = '0;
  logic [7:0] rd [0:7];
  logic oe_q = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_q && scl_m) viol++;
    oe_q <= sda_oe;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    if (glitch) begin
      wq(2); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q - 3);
    end else wq(Q);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); r = sda_ln; wq(Q); scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic rbyte(input bit last, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); d = {d[6:0], r}; end
    wq(Q); sda_m = last; wq(Q); scl_m = 1'b1; wq(Q);
    if (sda_oe) rel_bad++;
    wq(Q); scl_m = 1'b0;
  endtask

  task automatic do_read(input logic [6:0] a, input int n, output bit ack);
    logic [7:0] d;
    i_start();
    wbyte({a, 1'b1}, ack);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, d);
      rd[i] = d;
      if (i == 0 && chg_en) stat = chg_val;
    end
    i_stop();
  endtask

  task automatic send_cmd(input logic [6:0] a, input logic [7:0] c, input string req);
    bit aa, ac;
    i_start();
    wbyte({a, 1'b0}, aa);
    chk(req, "write addr ack", 32'(aa), 32'(a == ADDR));
    if (aa) begin
      wbyte(c, ac);
      chk("R3", "data byte ack", 32'(ac), 32'd1);
      if (c == CMD) mdl_arm = 1;
    end
    i_stop();
  endtask

  function automatic logic [7:0] exp_pay(int k, logic [4:0] s, bit arm, logic [8*NPAY-1:0] p);
    if (s[0]) return 8'hFF;
    if (!arm) return DFLT;
    if (k < NPAY) return p[8*k +: 8];
    return 8'hFF;
  endfunction

  task automatic read_check(input int n, input string req);
    logic [4:0] s0;
    logic [8*NPAY-1:0] p0;
    bit a, arm0;
    s0 = stat; p0 = pay; arm0 = mdl_arm;
    do_read(ADDR, n, a);
    mdl_arm = 0;
    chk(req, "read addr ack", 32'(a), 32'd1);
    chk(req, "header", 32'(rd[0]), 32'({3'b000, s0}));
    for (int k = 1; k < n; k++)
      chk(req, $sformatf("payload %0d", k - 1), 32'(rd[k]), 32'(exp_pay(k - 1, s0, arm0, p0)));
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    logic r;
    void'($urandom(32'd7));
    wq(5);
    chk("R1", "sda_oe in reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    wq(10);
    chk("R1", "sda_oe after reset", 32'(sda_oe), 32'd0);

    send_cmd(ADDR ^ 7'h01, CMD, "R2");
    do_read(ADDR ^ 7'h01, 1, a);
    chk("R2", "foreign read ack", 32'(a), 32'd0);
    chk("R2", "foreign read byte", 32'(rd[0]), 32'hFF);

    stat = 5'b10110; pay = 32'h8E1D_4700;
    send_cmd(ADDR, CMD, "R3");
    read_check(4, "R4 R5");

    read_check(3, "R7 unarmed");
    send_cmd(ADDR, 8'h11, "R3");
    read_check(3, "R7 unknown byte");
    send_cmd(ADDR, CMD, "R7");
    send_cmd(ADDR, 8'h11, "R7");
    read_check(3, "R7 arming kept");

    stat = 5'b00011; send_cmd(ADDR, CMD, "R6");
    read_check(NPAY + 1, "R6 busy");

    stat = 5'b01000; pay = 32'h0102_0304; send_cmd(ADDR, CMD, "R5");
    read_check(NPAY + 2, "R5 past end");

    stat = 5'b00000; chg_val = 5'b11111; chg_en = 1; send_cmd(ADDR, CMD, "R8");
    read_check(3, "R8 flags rise");
    stat = 5'b00001; chg_val = 5'b00000; send_cmd(ADDR, CMD, "R8");
    read_check(3, "R8 flags fall");
    chg_en = 0;

    stat = 5'b00000; pay = '0; send_cmd(ADDR, CMD, "R9");
    i_start(); wbyte({ADDR, 1'b1}, a);
    rbyte(1'b1, d);
    chk("R9", "header before NACK", 32'(d), 32'h00);
    rbyte(1'b1, d);
    chk("R9", "bus after NACK", 32'(d), 32'hFF);
    i_stop();
    mdl_arm = 0;

    pay = 32'hA5A5_5A5A; stat = 5'b00100;
    i_start();
    for (int i = 0; i < 4; i++) bit_io(1'b0, r);
    i_start();
    wbyte({ADDR, 1'b0}, a);
    chk("R11", "addr ack after restart", 32'(a), 32'd1);
    wbyte(CMD, a);
    mdl_arm = 1;
    i_stop();
    read_check(3, "R11 restart in byte");
    i_start(); wbyte({ADDR, 1'b0}, a); wbyte(CMD, a);
    i_start(); wbyte({ADDR, 1'b1}, a);
    chk("R11", "repeated start read ack", 32'(a), 32'd1);
    rbyte(1'b0, d); chk("R11", "header after repeated start", 32'(d), 32'h04);
    rbyte(1'b1, d); chk("R11", "payload after repeated start", 32'(d), 32'h5A);
    i_stop();

    stat = 5'b10010; pay = 32'h7733_C10F;
    send_cmd(ADDR, CMD, "R12");
    glitch = 1;
    read_check(4, "R12 glitch");
    glitch = 0;

    for (int it = 0; it < 28; it++) begin
      int sel;
      stat = 5'($urandom);
      pay = {$urandom};
      sel = int'($urandom % 8);
      if (sel == 0) send_cmd(ADDR, 8'($urandom) | 8'h01 & ~CMD, "R3");
      else if (sel == 1) begin end
      else if (sel == 2) send_cmd(ADDR ^ 7'h10, CMD, "R2");
      else send_cmd(ADDR, CMD, "R3");
      read_check(1 + int'($urandom % (NPAY + 2)), "R5 R6 R7 random");
    end

    chk("R10", "sda_oe changes with SCL high", 32'(viol), 32'd0);
    chk("R10", "drive during host ack slot", 32'(rel_bad), 32'd0);
    summary();
  end
endmodule